// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block gathers the interrupt causes of a UART into a single request line and an identification byte that software reads to learn which cause needs service. Five causes are handled: receiver line-status errors, receive data available (or FIFO trigger level reached), receive character timeout, transmit holding register empty, and modem-control input changes. Each cause has an enable bit, and the request line is further gated by a master interrupt enable.

Line-status and modem-change events arrive as one-cycle pulses. They are held in sticky flags until the matching status register read strobe arrives. The transmit-empty event is also held in a sticky flag. That flag is acknowledged in one of two ways: by an identification read made while transmit-empty is the reported cause, or by a write of new transmit data. Receive data available and character timeout are level inputs and are reported while they are high.

The identification byte is laid out as `{fifo_on, fifo_on, 2'b00, src_code[2:0], pend_n}`. Software decodes it at fixed positions, so the layout is fixed.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset all sticky flags are clear, `pend_n` is 1, `src_code` is 000, `msr_delta` is 0000 and `irq` is 0.
- R2: An enabled (`ien[2]`) pending line-status flag is reported with code 011, ahead of every other cause.
- R3: With no line-status cause reported, an enabled (`ien[0]`) high `rx_avail` is reported with code 010.
- R4: With neither of the above reported, an enabled (`ien[0]`) high `rx_timeout` is reported with code 110.
- R5: With no higher cause, an enabled (`ien[1]`) transmit-empty flag is reported with code 001. The flag is set by `thre_evt`. It is cleared by `thr_wr`, or by `iir_rd` in a cycle where code 001 is being reported with `pend_n` low. An `iir_rd` while another cause is reported leaves the flag set. A `thr_wr` in the same cycle as `thre_evt` leaves the flag clear.
- R6: Bits of `msr_chg` are latched into `msr_delta` and stay there until `msr_rd`. Any set bit with `ien[3]` is reported, at the lowest priority, with code 000.
- R7: A disabled cause is not reported. Its sticky flag is kept, and it is reported once its enable is set.
- R8: `pend_n` is 0 exactly when some enabled cause is active. With nothing pending, `src_code` is 000. `ident` bits 7 and 6 both equal `fifo_on`, bits 5:4 are 0, bits 3:1 are `src_code`, and bit 0 is `pend_n`.
- R9: `irq` is 1 exactly when `mie` is 1 and `pend_n` is 0.
- R10: The line-status flag is set by `line_evt` and cleared by `lsr_rd`. An event in the same cycle as a read, for either the line-status or the modem flags, leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien | input | 4 | Cause enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem change |
| mie | input | 1 | Master enable for `irq` |
| fifo_on | input | 1 | FIFOs enabled, mirrored into ident bits 7:6 |
| line_evt | input | 1 | Pulse: receiver error or break detected |
| rx_avail | input | 1 | Level: receive data ready or trigger reached |
| rx_timeout | input | 1 | Level: character timeout |
| thre_evt | input | 1 | Pulse: transmit holding register became empty |
| thr_wr | input | 1 | Strobe: transmit data written |
| msr_chg | input | 4 | Pulses: modem input changed (CTS, DSR, RI, DCD) |
| lsr_rd | input | 1 | Strobe: line status register read |
| msr_rd | input | 1 | Strobe: modem status register read |
| iir_rd | input | 1 | Strobe: identification value read |
| ident | output | 8 | Identification byte |
| src_code | output | 3 | Reported cause code |
| pend_n | output | 1 | 0 when an interrupt is pending |
| irq | output | 1 | Interrupt request |
| msr_delta | output | 4 | Latched modem change bits |

## Verification
The bench targets an identification read that arrives while a higher cause hides the transmit-empty flag. A design that clears the flag on any read would then lose that interrupt. It also drives an event and its clearing read in the same cycle; a design that lets the clear win drops an error or a modem change. Receive data and timeout are raised together to check their order, and a design with them swapped reports 110. Enables are turned off and back on to confirm that latched flags survive, where a design that clears flags on disable loses them.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  typedef enum logic [2:0] {
    SRC_MODEM  = 3'b000,
    SRC_THRE   = 3'b001,
    SRC_RXDATA = 3'b010,
    SRC_LINE   = 3'b011,
    SRC_CTO    = 3'b110
  } iid_src_e;

  // Fixed priority: line > rx data > timeout > tx empty > modem
  function automatic iid_src_e pick_source(input logic line_a, input logic rxd_a,
                                           input logic cto_a, input logic thre_a,
                                           input logic msr_a);
    if (line_a)      return SRC_LINE;
    else if (rxd_a)  return SRC_RXDATA;
    else if (cto_a)  return SRC_CTO;
    else if (thre_a) return SRC_THRE;
    else             return SRC_MODEM;
    // msr_a only decides pending state; code 000 is shared with idle
  endfunction

  function automatic logic [7:0] pack_ident(input logic fifo_on, input logic [2:0] code,
                                            input logic pend_n);
    return {fifo_on, fifo_on, 2'b00, code, pend_n};
  endfunction

endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);

  logic [W-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~{W{clr_i}}) | set_i;
  end

  assign flag_o = flag_q;

  // R10: a new event is never lost to a simultaneous clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i)));

  // R6: without set or clear the latched bits hold
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && set_i == '0) |=> $stable(flag_o));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_iid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_act,
  input  logic       rxd_act,
  input  logic       cto_act,
  input  logic       thre_act,
  input  logic       msr_act,
  output logic [2:0] code_o,
  output logic       pend_n_o
);

  iid_src_e sel;
  logic     any_act;

  assign any_act  = line_act | rxd_act | cto_act | thre_act | msr_act;
  assign sel      = pick_source(line_act, rxd_act, cto_act, thre_act, msr_act);
  assign code_o   = any_act ? sel : SRC_MODEM;
  assign pend_n_o = ~any_act;

  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_act |-> (code_o == 3'b011 && !pend_n_o));

  assert_rxd_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_act && !line_act) |-> code_o == 3'b010);

  assert_cto_third_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cto_act && !line_act && !rxd_act) |-> code_o == 3'b110);

  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_n_o |-> code_o == 3'b000);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_iid_pkg::*;
#(
  parameter int MSR_W = 4,
  parameter int IEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IEN_W-1:0] ien,
  input  logic             mie,
  input  logic             fifo_on,
  input  logic             line_evt,
  input  logic             rx_avail,
  input  logic             rx_timeout,
  input  logic             thre_evt,
  input  logic             thr_wr,
  input  logic [MSR_W-1:0] msr_chg,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             iir_rd,
  output logic [7:0]       ident,
  output logic [2:0]       src_code,
  output logic             pend_n,
  output logic             irq,
  output logic [MSR_W-1:0] msr_delta
);

  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  logic line_flag, thre_flag;
  logic thre_set, thre_clr, thre_ack_rd;
  logic line_act, rxd_act, cto_act, thre_act, msr_act;

  irq_sticky_flag #(.W(1)) u_line (
    .clk(clk), .rst_n(rst_n), .set_i(line_evt), .clr_i(lsr_rd), .flag_o(line_flag));

  irq_sticky_flag #(.W(MSR_W)) u_msr (
    .clk(clk), .rst_n(rst_n), .set_i(msr_chg), .clr_i(msr_rd), .flag_o(msr_delta));

  // transmit write means holding register is full again: it beats the event
  assign thre_set    = thre_evt & ~thr_wr;
  assign thre_ack_rd = iir_rd & ~pend_n & (src_code == SRC_THRE);
  assign thre_clr    = thr_wr | thre_ack_rd;

  irq_sticky_flag #(.W(1)) u_thre (
    .clk(clk), .rst_n(rst_n), .set_i(thre_set), .clr_i(thre_clr), .flag_o(thre_flag));

  assign line_act = ien[EN_LS] & line_flag;
  assign rxd_act  = ien[EN_RX] & rx_avail;
  assign cto_act  = ien[EN_RX] & rx_timeout;
  assign thre_act = ien[EN_TX] & thre_flag;
  assign msr_act  = ien[EN_MS] & (|msr_delta);

  irq_prio_enc u_enc (
    .clk(clk), .rst_n(rst_n),
    .line_act(line_act), .rxd_act(rxd_act), .cto_act(cto_act),
    .thre_act(thre_act), .msr_act(msr_act),
    .code_o(src_code), .pend_n_o(pend_n));

  assign ident = pack_ident(fifo_on, src_code, pend_n);
  assign irq   = mie & ~pend_n;

  assert_thre_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_ack_rd && !thre_evt) |=> !thre_flag);

  assert_thre_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_flag && iir_rd && src_code != SRC_THRE && !thr_wr) |=> thre_flag);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mie || pend_n) |-> !irq);

  assert_line_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !line_evt) |=> !line_flag);

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> pend_n);

endmodule

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] ien = 0;
  logic       mie = 0, fifo_on = 0, line_evt = 0, rx_avail = 0, rx_timeout = 0;
  logic       thre_evt = 0, thr_wr = 0, lsr_rd = 0, msr_rd = 0, iir_rd = 0;
  logic [3:0] msr_chg = 0;
  logic [7:0] ident;
  logic [2:0] src_code;
  logic       pend_n, irq;
  logic [3:0] msr_delta;

  int n_chk = 0, n_fail = 0;
  logic m_line = 0, m_thre = 0;
  logic [3:0] m_msr = 0;
  logic done = 0;

  always #2 clk = ~clk;

  uart_irq_ident dut_i (
    .clk(clk), .rst_n(rst_n), .ien(ien), .mie(mie), .fifo_on(fifo_on),
    .line_evt(line_evt), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
    .thre_evt(thre_evt), .thr_wr(thr_wr), .msr_chg(msr_chg),
    .lsr_rd(lsr_rd), .msr_rd(msr_rd), .iir_rd(iir_rd),
    .ident(ident), .src_code(src_code), .pend_n(pend_n), .irq(irq),
    .msr_delta(msr_delta));

  // expected code with pending flag in bit 3
  function automatic logic [3:0] exp_src();
    if (ien[2] && m_line)            return 4'b1011;
    if (ien[0] && rx_avail)          return 4'b1010;
    if (ien[0] && rx_timeout)        return 4'b1110;
    if (ien[1] && m_thre)            return 4'b1001;
    if (ien[3] && (m_msr != 0))      return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic string req_of(input logic [3:0] e);
    case (e)
      4'b1011: return "R2";
      4'b1010: return "R3";
      4'b1110: return "R4";
      4'b1001: return "R5";
      4'b1000: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  // compare outputs with model, then advance model to the next edge
  task automatic check_and_step();
    logic [3:0] e;
    logic ack;
    #1;
    e = exp_src();
    chk(req_of(e), {29'd0, src_code}, {29'd0, e[2:0]});
    chk("R8", {24'd0, ident}, {24'd0, fifo_on, fifo_on, 2'b00, e[2:0], ~e[3]});
    chk("R9", {31'd0, irq}, {31'd0, mie & e[3]});
    chk("R6", {28'd0, msr_delta}, {28'd0, m_msr});
    ack   = iir_rd && (e == 4'b1001);
    m_line = (m_line & ~lsr_rd) | line_evt;
    m_msr  = (m_msr & ~{4{msr_rd}}) | msr_chg;
    m_thre = thr_wr ? 1'b0 : ((m_thre & ~ack) | thre_evt);
  endtask

  task automatic idle();
    line_evt = 0; thre_evt = 0; thr_wr = 0; msr_chg = 0;
    lsr_rd = 0; msr_rd = 0; iir_rd = 0;
  endtask

  task automatic cyc();
    check_and_step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    // R1 reset state
    chk("R1", {31'd0, pend_n}, 32'd1);
    chk("R1", {29'd0, src_code}, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);
    chk("R1", {28'd0, msr_delta}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ien = 4'hF; mie = 1; fifo_on = 1;
    // R5: tx empty reported, hidden read keeps it, own read clears it
    thre_evt = 1; cyc();
    line_evt = 1; cyc();
    iir_rd = 1; cyc();              // line reported: thre stays
    lsr_rd = 1; cyc();              // R10 line cleared
    chk("R5", {31'd0, pend_n}, 32'd0);
    iir_rd = 1; cyc();              // clears thre
    chk("R5", {31'd0, pend_n}, 32'd1);
    // R5: write beats a simultaneous event
    thre_evt = 1; thr_wr = 1; cyc();
    cyc();
    // R10: event with read in the same cycle stays
    line_evt = 1; cyc();
    line_evt = 1; lsr_rd = 1; cyc();
    cyc();
    lsr_rd = 1; cyc();
    // R3/R4 ordering
    rx_avail = 1; rx_timeout = 1; cyc();
    rx_avail = 0; cyc();
    rx_timeout = 0;
    // R7: disabled modem change kept, reported once enabled
    ien = 4'b0111; msr_chg = 4'b0101; cyc();
    cyc();
    ien = 4'hF; cyc();
    msr_chg = 4'b1000; msr_rd = 1; cyc();
    msr_rd = 1; cyc();
    // R9 master enable off
    mie = 0; thre_evt = 1; cyc();
    cyc();
    thr_wr = 1; mie = 1; cyc();
    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) ien = 4'($urandom);
      if (i % 97 == 0)  mie = 1'($urandom);
      if (i % 131 == 0) fifo_on = 1'($urandom);
      line_evt   = ($urandom % 10) == 0;
      rx_avail   = ($urandom % 6) == 0;
      rx_timeout = ($urandom % 8) == 0;
      thre_evt   = ($urandom % 7) == 0;
      thr_wr     = ($urandom % 9) == 0;
      msr_chg    = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      lsr_rd     = ($urandom % 5) == 0;
      msr_rd     = ($urandom % 6) == 0;
      iir_rd     = ($urandom % 3) == 0;
      cyc();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule